// File: doc/BRIEF.md
# SPI Hold Pause Controller

This block gives the serial front end of an SPI slave its pause function. It samples chip select, serial clock, serial data in and the active-low pause pin into a system clock domain. It keeps a small state machine that decides when the slave is paused. While paused, the serial output driver is released and every serial clock edge is masked, so that the bit counter, the receive shift register and the output bit register stay exactly as they were. When the pause ends, the same output bit is driven again and reception resumes from the same bit position.

Entry into and exit from the pause depend on the serial clock level at the moment the pause pin changes. If the clock is low, the change takes effect at once. If the clock is high, the change waits until the clock next falls. Deselecting the slave clears the pause, and a new selection always starts out of the pause. The instruction decoder and the memory sit outside this block. They see only the qualified clock edge strobes, the received words and the pause flag, and they present the next output bit on `so_data_i`.

Top module: `spi_hold_ctrl`

## Requirements
- R1: After reset, `hold_o`, `so_oe_o`, `so_o`, `rx_valid_o` and `bit_cnt_o` are all 0.
- R2: With the slave selected and SCK low, a falling `hold_ni` sets `hold_o` on the third `clk_i` rising edge after the change.
- R3: With the slave selected and SCK high, a falling `hold_ni` leaves `hold_o` at 0 while SCK stays high. `hold_o` rises three edges after SCK falls, and that SCK fall is still counted as a normal output shift.
- R4: While paused with SCK low, a rising `hold_ni` clears `hold_o` on the third `clk_i` rising edge after the change.
- R5: While paused with SCK high, a rising `hold_ni` keeps `hold_o` at 1 until SCK falls, and that SCK fall is not counted.
- R6: `so_oe_o` is 0 whenever `hold_o` is 1 or the slave is deselected. When the pause ends, `so_oe_o` returns to 1 with `so_o` unchanged from before the pause.
- R7: SCK edges and SI values during a pause have no effect: `bit_cnt_o`, the received word and `rx_valid_o` behave as if the paused clocks never occurred.
- R8: While `cs_ni` is high, `hold_o` is 0 whatever `hold_ni` does, `bit_cnt_o` is 0 and `so_o` is 0. Raising `cs_ni` during a pause clears the pause.
- R9: Bits are received MSB first on qualified SCK rising edges. `bit_cnt_o` counts them modulo `WORD_W`. The rise that completes a word gives a one-cycle `rx_valid_o` pulse with the word on `rx_byte_o`.
- R10: `so_o` loads `so_data_i` on each qualified SCK falling edge and on no other edge.
- R11: A `hold_ni` low pulse that begins and ends while SCK stays high causes no pause and costs no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select pin, active low, asynchronous |
| sck_i | input | 1 | Serial clock pin, asynchronous |
| si_i | input | 1 | Serial data in pin |
| hold_ni | input | 1 | Pause pin, active low |
| so_data_i | input | 1 | Next output bit from the core |
| hold_o | output | 1 | Pause active |
| so_o | output | 1 | Serial output bit |
| so_oe_o | output | 1 | Serial output drive enable |
| sck_rise_o | output | 1 | Qualified SCK rise strobe |
| sck_fall_o | output | 1 | Qualified SCK fall strobe |
| bit_cnt_o | output | $clog2(WORD_W) | Bit position within the word |
| rx_byte_o | output | WORD_W | Last complete received word |
| rx_valid_o | output | 1 | One-cycle pulse on word completion |

## Verification
The key coincidence is an SCK falling edge in the same sampled cycle as a pause state change. A fall that starts a pending pause must still shift the output, and a fall that ends a pending release must not. The bench provokes both cases by moving `hold_ni` while SCK is high and then dropping SCK. Before that fall it sets `so_data_i` to the complement of the held bit, so a wrongly counted or wrongly masked fall shows up on `so_o`. The sweep places the pause at every bit position, with every combination of SCK level at entry and at exit. Each word is judged by its received value, its single completion pulse and `bit_cnt_o`.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  typedef enum logic [1:0] {
    HS_RUN   = 2'd0,
    HS_ENTER = 2'd1,  // pause requested, waiting for SCK low
    HS_HELD  = 2'd2,
    HS_LEAVE = 2'd3   // release requested, waiting for SCK low
  } hold_state_e;
endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
  parameter int unsigned N = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL[i]}};
      else         chain_q <= {chain_q[STAGES-2:0], d_i[i]};
    end
    assign q_o[i] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/spi_hold_fsm.sv
module spi_hold_fsm
  import spi_hold_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_n_i,
  input  logic sck_i,
  input  logic hold_n_i,
  output logic hold_o,
  output logic qual_o
);
  hold_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (cs_n_i) begin
      state_d = HS_RUN;
    end else begin
      unique case (state_q)
        HS_RUN:   if (!hold_n_i) state_d = sck_i ? HS_ENTER : HS_HELD;
        HS_ENTER: if (hold_n_i) state_d = HS_RUN;
                  else if (!sck_i) state_d = HS_HELD;
        HS_HELD:  if (hold_n_i) state_d = sck_i ? HS_LEAVE : HS_RUN;
        HS_LEAVE: if (!hold_n_i) state_d = HS_HELD;
                  else if (!sck_i) state_d = HS_RUN;
        default:  state_d = HS_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= HS_RUN;
    else         state_q <= state_d;
  end

  assign hold_o = (state_q == HS_HELD) || (state_q == HS_LEAVE);
  // edges seen in ENTER still count: the pause starts after that SCK fall
  assign qual_o = !cs_n_i && ((state_q == HS_RUN) || (state_q == HS_ENTER));

  a_r2_enter_on_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == HS_RUN && !cs_n_i && !hold_n_i && !sck_i) |=> hold_o);
  a_r3_enter_waits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == HS_RUN && !cs_n_i && !hold_n_i && sck_i) |=> !hold_o);
  a_r5_exit_waits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o && !cs_n_i && hold_n_i && sck_i) |=> hold_o);
  a_r8_deselect_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_i |=> !hold_o);
endmodule

// File: rtl/spi_hold_shift.sv
module spi_hold_shift #(
  parameter int unsigned WORD_W = 8,
  localparam int unsigned CNT_W = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              hold_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              si_i,
  input  logic              so_data_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [WORD_W-1:0] rx_byte_o,
  output logic              rx_valid_o,
  output logic              so_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] shift_q, rx_q;
  logic              valid_q, so_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; shift_q <= '0; rx_q <= '0; valid_q <= 1'b0; so_q <= 1'b0;
    end else if (cs_n_i) begin
      cnt_q <= '0; shift_q <= '0; valid_q <= 1'b0; so_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (rise_i) begin
        shift_q <= {shift_q[WORD_W-2:0], si_i};
        if (cnt_q == LAST) begin
          cnt_q   <= '0;
          rx_q    <= {shift_q[WORD_W-2:0], si_i};
          valid_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      if (fall_i) so_q <= so_data_i;
    end
  end

  assign cnt_o      = cnt_q;
  assign rx_byte_o  = rx_q;
  assign rx_valid_o = valid_q;
  assign so_o       = so_q;

  a_r7_cnt_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !cs_n_i) |=> $stable(cnt_q) && $stable(shift_q));
  a_r10_so_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !cs_n_i) |=> $stable(so_q));
  a_r9_valid_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> (cnt_q == '0));
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl #(
  parameter int unsigned WORD_W = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_W = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              si_i,
  input  logic              hold_ni,
  input  logic              so_data_i,
  output logic              hold_o,
  output logic              so_o,
  output logic              so_oe_o,
  output logic              sck_rise_o,
  output logic              sck_fall_o,
  output logic [CNT_W-1:0]  bit_cnt_o,
  output logic [WORD_W-1:0] rx_byte_o,
  output logic              rx_valid_o
);
  logic [3:0] pins_raw, pins_syn;
  logic s_cs_n, s_hold_n, s_sck, s_si;
  logic sck_d_q, rise, fall, hold, qual;

  assign pins_raw = {cs_ni, hold_ni, sck_i, si_i};

  spi_hold_sync #(.N(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1100)) u_sync (
    .clk_i, .rst_ni, .d_i(pins_raw), .q_o(pins_syn)
  );
  assign {s_cs_n, s_hold_n, s_sck, s_si} = pins_syn;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_d_q <= 1'b0;
    else         sck_d_q <= s_sck;
  end
  assign rise = s_sck & ~sck_d_q;
  assign fall = ~s_sck & sck_d_q;

  spi_hold_fsm u_fsm (
    .clk_i, .rst_ni, .cs_n_i(s_cs_n), .sck_i(s_sck), .hold_n_i(s_hold_n),
    .hold_o(hold), .qual_o(qual)
  );

  assign sck_rise_o = rise & qual;
  assign sck_fall_o = fall & qual;

  spi_hold_shift #(.WORD_W(WORD_W)) u_shift (
    .clk_i, .rst_ni, .cs_n_i(s_cs_n), .hold_i(hold),
    .rise_i(sck_rise_o), .fall_i(sck_fall_o), .si_i(s_si), .so_data_i,
    .cnt_o(bit_cnt_o), .rx_byte_o, .rx_valid_o, .so_o
  );

  assign hold_o  = hold;
  assign so_oe_o = ~s_cs_n & ~hold;

  a_r9_no_strobe_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sck_rise_o && sck_fall_o));
  a_r7_no_strobe_in_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(hold) && hold) |-> !sck_rise_o);
endmodule

// File: tb/sim_spi_hold_ctrl.sv
module sim_spi_hold_ctrl;
  logic clk = 0, rst_n = 0;
  logic cs_n = 1, sck = 0, si = 0, hold_n = 1, so_data = 0;
  logic hold, so, so_oe, rise_s, fall_s, rx_valid;
  logic [2:0] cnt;
  logic [7:0] rx_byte;
  int n_chk = 0, n_fail = 0, rx_pulses = 0;
  logic [7:0] rx_last = 0;
  bit done = 0;
  logic so_exp;

  always #10 clk = ~clk;

  spi_hold_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .si_i(si),
    .hold_ni(hold_n), .so_data_i(so_data), .hold_o(hold), .so_o(so),
    .so_oe_o(so_oe), .sck_rise_o(rise_s), .sck_fall_o(fall_s),
    .bit_cnt_o(cnt), .rx_byte_o(rx_byte), .rx_valid_o(rx_valid)
  );

  always @(negedge clk) if (rx_valid) begin rx_pulses++; rx_last = rx_byte; end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n = 4);
    repeat (n) @(negedge clk);
  endtask

  // enters with SCK low and pause active
  task automatic pause_body(input bit out_hi, input int cnt_exp);
    chk(so_oe == 0, "R6 oe off", so_oe, 0);
    so_data = ~so_exp; si = ~si;
    sck = 1; step();
    chk(cnt == cnt_exp[2:0], "R7 cnt frozen", cnt, cnt_exp);
    sck = 0; step();
    chk(so == so_exp, "R10 no load in pause", so, so_exp);
    sck = 1; si = ~si; step();
    if (out_hi) begin
      hold_n = 1; step();
      chk(hold == 1, "R5 exit waits", hold, 1);
      sck = 0; step();
      chk(hold == 0, "R5 exit on low", hold, 0);
    end else begin
      sck = 0; step();
      hold_n = 1; step(3);
      chk(hold == 0, "R4 exit immediate", hold, 0);
      step(1);
    end
    chk(so_oe == 1, "R6 oe back", so_oe, 1);
    chk(so == so_exp, "R6 same bit", so, so_exp);
    chk(cnt == cnt_exp[2:0], "R7 cnt after", cnt, cnt_exp);
  endtask

  task automatic xfer(input logic [7:0] rxb, input logic [7:0] txb,
                      input int hk, input bit in_hi, input bit out_hi);
    int p0 = rx_pulses;
    cs_n = 0; step();
    so_exp = 0;
    for (int j = 0; j < 8; j++) begin
      if (j == hk && !in_hi) begin
        hold_n = 0; step(3);
        chk(hold == 1, "R2 enter immediate", hold, 1);
        step(1);
        pause_body(out_hi, j);
      end
      si = rxb[7-j]; sck = 1; step();
      so_data = txb[7-j];
      if (j == hk && in_hi) begin
        hold_n = 0; step();
        chk(hold == 0, "R3 entry waits", hold, 0);
        sck = 0; step();
        so_exp = txb[7-j];
        chk(hold == 1, "R3 entry on low", hold, 1);
        chk(so == so_exp, "R3 entry fall counted", so, so_exp);
        pause_body(out_hi, (j + 1) % 8);
      end else begin
        sck = 0; step();
        so_exp = txb[7-j];
        chk(so == so_exp, "R10 shift", so, so_exp);
      end
      chk(cnt == 3'((j + 1) % 8), "R9 count", cnt, (j + 1) % 8);
    end
    chk(rx_pulses == p0 + 1, "R9 one pulse", rx_pulses - p0, 1);
    chk(rx_last == rxb, "R9 word", rx_last, rxb);
    cs_n = 1; step();
    chk(cnt == 0 && so_oe == 0 && so == 0, "R8 deselect", {cnt, so_oe, so}, 0);
  endtask

  initial begin
    step(3);
    chk(hold == 0 && so_oe == 0 && so == 0 && cnt == 0 && rx_valid == 0,
        "R1 reset", {hold, so_oe, so, cnt, rx_valid}, 0);
    rst_n = 1; step();
    // R8: pause pin ignored while deselected
    hold_n = 0; step(6);
    chk(hold == 0, "R8 no hold when deselected", hold, 0);
    hold_n = 1; step();
    // R8: deselect during pause
    cs_n = 0; step(); hold_n = 0; step();
    chk(hold == 1, "R8 hold set", hold, 1);
    cs_n = 1; step();
    chk(hold == 0, "R8 cleared by deselect", hold, 0);
    hold_n = 1; cs_n = 0; step();
    chk(hold == 0 && so_oe == 1, "R8 new select out of hold", hold, 0);
    // R11: glitch while SCK high
    si = 1; sck = 1; step();
    hold_n = 0; step(); hold_n = 1; step();
    sck = 0; step();
    chk(hold == 0, "R11 no pause", hold, 0);
    chk(cnt == 1, "R11 bit kept", cnt, 1);
    cs_n = 1; step();
    // sweep: pause at every bit, every SCK level at entry and exit
    for (int hk = 0; hk < 8; hk++)
      for (int m = 0; m < 4; m++)
        xfer(8'((hk * 37 + m * 91) ^ 8'hA5), 8'((hk * 53 + m * 29) ^ 8'h3C),
             hk, m[0], m[1]);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule